// File: doc/BRIEF.md
# Bounds-Checked Data Memory Access Unit

This unit sits between a processor's load/store stage and a small word-addressed data memory. It serves four kinds of request. Direct loads and direct stores use an address taken from the instruction and are not bounds-tested. Bounded loads and bounded stores use an address taken from a register. Each bounded request also carries a lower and an upper limit, which are literal constants from the instruction. The unit performs a bounded request only when its address falls inside those limits.

A request that fails its check is dropped. It writes nothing, and a load returns zero. The unit raises a violation strobe for one cycle and records the offending address. Any address at or beyond the implemented depth counts as a violation for every kind of request, so the memory never aliases. The memory holds 64-bit words and starts all-zero. A load answers one cycle after it is accepted, with a valid strobe.

Top module: `bnd_mem_unit`

## Requirements
- R1: After reset, `rsp_valid`, `rsp_rdata`, `viol_pulse` and `viol_addr` are zero, and every memory word reads as zero.
- R2: The kind code is `req_kind[1]` = bounded, `req_kind[0]` = store. A load accepted in cycle t gives `rsp_valid` high for exactly cycle t+1, with the word in `rsp_rdata`. A store written in cycle t is visible to a load issued in cycle t+1 or later.
- R3: Direct requests (`req_kind` 00 load, 01 store) ignore `req_lo` and `req_hi`. They succeed even when the address lies outside those limits.
- R4: A bounded load (`req_kind` 10) whose address is within the limits returns the stored word, and `viol_pulse` stays low.
- R5: A bounded store (`req_kind` 11) whose address is within the limits writes `req_wdata` to that word.
- R6: The limit test is inclusive. An address equal to `req_lo` or to `req_hi` passes.
- R7: The limit test is unsigned. With `req_hi` = 64'hFFFF_FFFF_FFFF_FFF0 and `req_lo` = 1, address 5 passes.
- R8: A bounded store outside its limits leaves memory unchanged. In the next cycle `viol_pulse` is high and `viol_addr` holds the request address. The store produces no `rsp_valid`.
- R9: A bounded load outside its limits gives `rsp_valid` high with `rsp_rdata` zero and `viol_pulse` high in the next cycle.
- R10: An address of `DEPTH` (16 by default) or above is a violation for all four kinds. A direct store there changes no word, including the word that its low address bits select. A direct load there returns zero.
- R11: `viol_pulse` is high for one cycle per violating request. `viol_addr` keeps its value until the next violation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_kind | input | 2 | Bit 1 bounded, bit 0 store |
| req_addr | input | 64 | Word address |
| req_wdata | input | 64 | Store data |
| req_lo | input | 64 | Lower limit (inclusive) for bounded kinds |
| req_hi | input | 64 | Upper limit (inclusive) for bounded kinds |
| rsp_valid | output | 1 | Load response valid |
| rsp_rdata | output | 64 | Load response data |
| viol_pulse | output | 1 | One-cycle violation strobe |
| viol_addr | output | 64 | Address of the latest violation |

## Verification
A word corrupted in storage, or a write decoded to the wrong index, only shows up when that word is loaded. The bench therefore reads back every word that a blocked or out-of-depth store could have touched, right after that store. A fault in the limit compare shows on `viol_pulse` and `rsp_rdata` one cycle after the request. The bench places addresses exactly on each limit, and one limit with its top bit set, so that an off-by-one or signed-compare fault flips the outcome. A stale violation register shows as `viol_addr` changing, or `viol_pulse` staying high, in the cycle after a clean request.

// File: rtl/bnd_mem_pkg.sv
package bnd_mem_pkg;
  localparam int unsigned WORD_W = 64;
  localparam int unsigned ADDR_W = 64;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [ADDR_W-1:0] addr_t;

  typedef enum logic [1:0] {
    KIND_DLOAD  = 2'b00,
    KIND_DSTORE = 2'b01,
    KIND_BLOAD  = 2'b10,
    KIND_BSTORE = 2'b11
  } kind_e;
endpackage

// File: rtl/bnd_mem_range.sv
module bnd_mem_range
  import bnd_mem_pkg::*;
#(
  parameter int unsigned DEPTH = 16
) (
  input  addr_t addr,
  input  addr_t lo,
  input  addr_t hi,
  input  logic  bounded,
  output logic  allow
);
  localparam addr_t DEPTH_A = addr_t'(DEPTH);

  logic in_depth;
  logic above_lo;
  logic below_hi;

  always_comb begin
    in_depth = (addr < DEPTH_A);
    above_lo = (addr >= lo);
    below_hi = (addr <= hi);
    allow    = in_depth && (!bounded || (above_lo && below_hi));
  end
endmodule

// File: rtl/bnd_mem_store.sv
module bnd_mem_store
  import bnd_mem_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  word_t            wr_data,
  input  logic [IDX_W-1:0] rd_idx,
  output word_t            rd_data
);
  word_t words_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    logic  hit;
    word_t word_d;

    always_comb begin
      hit    = wr_en && (wr_idx == IDX_W'(g));
      word_d = hit ? wr_data : words_q[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        words_q[g] <= '0;
      end else if (hit) begin
        words_q[g] <= word_d;
      end
    end
  end

  always_comb begin
    rd_data = words_q[rd_idx];
  end
endmodule

// File: rtl/bnd_mem_unit.sv
module bnd_mem_unit
  import bnd_mem_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic [1:0]  req_kind,
  input  logic [63:0] req_addr,
  input  logic [63:0] req_wdata,
  input  logic [63:0] req_lo,
  input  logic [63:0] req_hi,
  output logic        rsp_valid,
  output logic [63:0] rsp_rdata,
  output logic        viol_pulse,
  output logic [63:0] viol_addr
);
  kind_e            kind;
  logic             is_store;
  logic             is_bounded;
  logic             allow;
  logic             wr_en;
  logic             rd_fire;
  logic [IDX_W-1:0] idx;
  word_t            rd_word;

  logic  rsp_valid_d, rsp_valid_q;
  word_t rsp_rdata_d, rsp_rdata_q;
  logic  viol_d,      viol_q;
  addr_t viol_addr_d, viol_addr_q;
  logic  rsp_en;

  always_comb begin
    kind       = kind_e'(req_kind);
    is_store   = (kind == KIND_DSTORE) || (kind == KIND_BSTORE);
    is_bounded = (kind == KIND_BLOAD)  || (kind == KIND_BSTORE);
    idx        = req_addr[IDX_W-1:0];
  end

  bnd_mem_range #(.DEPTH(DEPTH)) u_range (
    .addr    (req_addr),
    .lo      (req_lo),
    .hi      (req_hi),
    .bounded (is_bounded),
    .allow   (allow)
  );

  always_comb begin
    wr_en   = req_valid && is_store && allow;
    rd_fire = req_valid && !is_store;
  end

  bnd_mem_store #(.DEPTH(DEPTH)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_idx  (idx),
    .wr_data (req_wdata),
    .rd_idx  (idx),
    .rd_data (rd_word)
  );

  // next-state
  always_comb begin
    rsp_valid_d = rd_fire;
    rsp_en      = rd_fire;
    rsp_rdata_d = allow ? rd_word : '0;
    viol_d      = req_valid && !allow;
    viol_addr_d = viol_d ? req_addr : viol_addr_q;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      viol_q      <= 1'b0;
      viol_addr_q <= '0;
    end else begin
      rsp_valid_q <= rsp_valid_d;
      viol_q      <= viol_d;
      viol_addr_q <= viol_addr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_rdata_q <= '0;
    end else if (rsp_en) begin
      rsp_rdata_q <= rsp_rdata_d;
    end
  end

  always_comb begin
    rsp_valid  = rsp_valid_q;
    rsp_rdata  = rsp_rdata_q;
    viol_pulse = viol_q;
    viol_addr  = viol_addr_q;
  end
endmodule

// File: rtl/bnd_mem_unit_sva.sv
module bnd_mem_unit_sva #(
  parameter int unsigned DEPTH = 16
) (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic [1:0]  req_kind,
  input logic [63:0] req_addr,
  input logic [63:0] req_wdata,
  input logic [63:0] req_lo,
  input logic [63:0] req_hi,
  input logic        rsp_valid,
  input logic [63:0] rsp_rdata,
  input logic        viol_pulse,
  input logic [63:0] viol_addr
);
  localparam logic [63:0] DEPTH_A = 64'(DEPTH);

  // R2
  load_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_kind[0] |=> rsp_valid);

  // R8
  store_no_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_kind[0] |=> !rsp_valid);

  // R9
  blocked_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && viol_pulse |-> rsp_rdata == 64'd0);

  // R10
  depth_viol_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && (req_addr >= DEPTH_A) |=> viol_pulse);

  // R6
  in_limits_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_kind[1] && (req_addr >= req_lo) && (req_addr <= req_hi)
    && (req_addr < DEPTH_A) |=> !viol_pulse);

  // R3
  direct_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_kind[1] && (req_addr < DEPTH_A) |=> !viol_pulse);

  // R11
  viol_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !viol_pulse |-> $stable(viol_addr));

  // R8
  viol_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    viol_pulse |-> viol_addr == $past(req_addr));
endmodule

bind bnd_mem_unit bnd_mem_unit_sva #(.DEPTH(DEPTH)) u_sva (.*);

// File: tb/bnd_mem_unit_bench.sv
module bnd_mem_unit_bench;
  localparam int unsigned DEPTH = 16;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic [1:0]  req_kind;
  logic [63:0] req_addr;
  logic [63:0] req_wdata;
  logic [63:0] req_lo;
  logic [63:0] req_hi;
  logic        rsp_valid;
  logic [63:0] rsp_rdata;
  logic        viol_pulse;
  logic [63:0] viol_addr;

  int unsigned n_checks;
  int unsigned n_fail;
  bit          done;

  localparam logic [1:0] K_DL = 2'b00, K_DS = 2'b01, K_BL = 2'b10, K_BS = 2'b11;
  localparam logic [63:0] VA = 64'hA5A5_0000_1111_2222;
  localparam logic [63:0] VB = 64'h0123_4567_89AB_CDEF;
  localparam logic [63:0] VC = 64'hDEAD_BEEF_CAFE_F00D;
  localparam logic [63:0] VE = 64'h5555_AAAA_5555_AAAA;

  bnd_mem_unit #(.DEPTH(DEPTH)) u_bnd_mem_unit (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_lo(req_lo), .req_hi(req_hi),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .viol_pulse(viol_pulse), .viol_addr(viol_addr)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Drive one request at a falling edge, let one rising edge take it,
  // and return at the next falling edge with the request withdrawn.
  task automatic op(input logic [1:0] k, input logic [63:0] a, input logic [63:0] d,
                    input logic [63:0] lo, input logic [63:0] hi);
    @(negedge clk);
    req_valid = 1'b1; req_kind = k; req_addr = a; req_wdata = d;
    req_lo = lo; req_hi = hi;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic expect_load(input string tag, input logic [63:0] exp_data,
                             input logic exp_viol);
    chk(rsp_valid == 1'b1, tag, 64'(rsp_valid), 64'd1);
    chk(rsp_rdata == exp_data, tag, rsp_rdata, exp_data);
    chk(viol_pulse == exp_viol, tag, 64'(viol_pulse), 64'(exp_viol));
  endtask

  task automatic t_reset();
    chk(rsp_valid == 1'b0 && viol_pulse == 1'b0, "R1 flags", 64'({rsp_valid, viol_pulse}), 64'd0);
    chk(rsp_rdata == 64'd0, "R1 rdata", rsp_rdata, 64'd0);
    chk(viol_addr == 64'd0, "R1 viol_addr", viol_addr, 64'd0);
    op(K_DL, 64'd7, 64'd0, 64'd0, 64'd0);
    expect_load("R1 word zero", 64'd0, 1'b0);
  endtask

  task automatic t_direct();
    op(K_DS, 64'd3, VA, 64'd10, 64'd12);
    chk(viol_pulse == 1'b0, "R3 direct store limits ignored", 64'(viol_pulse), 64'd0);
    chk(rsp_valid == 1'b0, "R2 store no response", 64'(rsp_valid), 64'd0);
    op(K_DL, 64'd3, 64'd0, 64'd10, 64'd12);
    expect_load("R2 R3 direct readback", VA, 1'b0);
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R2 single valid", 64'(rsp_valid), 64'd0);
  endtask

  task automatic t_bounded();
    op(K_BS, 64'd5, VB, 64'd4, 64'd6);
    chk(viol_pulse == 1'b0, "R5 bounded store ok", 64'(viol_pulse), 64'd0);
    op(K_BL, 64'd5, 64'd0, 64'd4, 64'd6);
    expect_load("R4 R5 bounded readback", VB, 1'b0);
  endtask

  task automatic t_edges();
    op(K_BS, 64'd8, VE, 64'd8, 64'd9);
    chk(viol_pulse == 1'b0, "R6 store at lower limit", 64'(viol_pulse), 64'd0);
    op(K_BL, 64'd9, 64'd0, 64'd8, 64'd9);
    expect_load("R6 load at upper limit", 64'd0, 1'b0);
    op(K_BL, 64'd8, 64'd0, 64'd8, 64'd8);
    expect_load("R6 single-word window", VE, 1'b0);
  endtask

  task automatic t_unsigned();
    op(K_BL, 64'd5, 64'd0, 64'd1, 64'hFFFF_FFFF_FFFF_FFF0);
    expect_load("R7 unsigned limit", VB, 1'b0);
  endtask

  task automatic t_block_store();
    op(K_BS, 64'd3, VC, 64'd4, 64'd6);
    chk(viol_pulse == 1'b1, "R8 store violation", 64'(viol_pulse), 64'd1);
    chk(viol_addr == 64'd3, "R8 violation address", viol_addr, 64'd3);
    chk(rsp_valid == 1'b0, "R8 no response", 64'(rsp_valid), 64'd0);
    op(K_DL, 64'd3, 64'd0, 64'd0, 64'd0);
    expect_load("R8 memory unchanged", VA, 1'b0);
    chk(viol_addr == 64'd3, "R11 address held", viol_addr, 64'd3);
  endtask

  task automatic t_block_load();
    op(K_BL, 64'd5, 64'd0, 64'd6, 64'd9);
    expect_load("R9 blocked load zero", 64'd0, 1'b1);
    chk(viol_addr == 64'd5, "R9 violation address", viol_addr, 64'd5);
    @(negedge clk);
    chk(viol_pulse == 1'b0, "R11 one-cycle pulse", 64'(viol_pulse), 64'd0);
    chk(viol_addr == 64'd5, "R11 address held idle", viol_addr, 64'd5);
  endtask

  task automatic t_depth();
    op(K_DS, 64'(DEPTH + 3), VC, 64'd0, 64'hFFFF_FFFF_FFFF_FFFF);
    chk(viol_pulse == 1'b1, "R10 direct store beyond depth", 64'(viol_pulse), 64'd1);
    chk(viol_addr == 64'(DEPTH + 3), "R10 address", viol_addr, 64'(DEPTH + 3));
    op(K_DL, 64'd3, 64'd0, 64'd0, 64'd0);
    expect_load("R10 no aliased write", VA, 1'b0);
    op(K_DL, 64'h8000_0000_0000_0005, 64'd0, 64'd0, 64'd0);
    expect_load("R10 direct load beyond depth", 64'd0, 1'b1);
    op(K_BL, 64'(DEPTH), 64'd0, 64'd0, 64'hFFFF_FFFF_FFFF_FFFF);
    expect_load("R10 bounded load at depth", 64'd0, 1'b1);
  endtask

  initial begin
    n_checks = 0; n_fail = 0; done = 1'b0;
    req_valid = 1'b0; req_kind = 2'b00; req_addr = '0; req_wdata = '0;
    req_lo = '0; req_hi = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_direct();
    t_bounded();
    t_edges();
    t_unsigned();
    t_block_store();
    t_block_load();
    t_depth();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule